// File: doc/BRIEF.md
# NOR Flash Identification Probe

This block identifies a parallel NOR flash with an 8-bit data bus once the chip has powered up. A one-cycle `start` pulse makes it run the whole probe. It writes the three-write unlock-and-identify command. It waits a settle time counted in clock cycles. It reads the manufacturer code and then the device code. Last, it writes the read-reset command, so the flash is back in normal array-read mode. The result stays latched until the next probe: whether the part was recognised, how many sectors it has, and its size in bytes.

Two device kinds are known. The first is a 16-Mbit part with small boot sectors at the bottom of its map. The second is a 64-Mbit part with equal 64 KiB sectors. While a result is held, the `sect_idx` input is looked up without any clock delay and gives the start address of that sector on `sect_base`. Unless the `LOW_BOOT` parameter is set, the device sits high in the address space: 0xE00000 is added to every sector start of the 16-Mbit part, and 0x800000 to every sector start of the 64-Mbit part.

The sequencer walks through these states:
- `S_IDLE` goes to `S_UNLK_A` on `start`.
- `S_UNLK_A` goes to `S_UNLK_B`, then `S_AUTOSEL`, then `S_SETTLE`.
- `S_SETTLE` goes to `S_RD_MFR` once the settle counter has elapsed.
- `S_RD_MFR` is followed by `S_CAP_MFR`, `S_RD_DEV`, `S_CAP_DEV`, `S_EXIT` and `S_DONE`.
- `S_DONE` always returns to `S_IDLE`.

Top module: `nor_id_probe`

## Requirements
- R1: One cycle after `start` is seen in idle, three writes follow in consecutive cycles: 0xAA to address 0xAAA, then 0x55 to address 0x555, then 0x90 to address 0xAAA.
- R2: The first identification read is issued exactly WAIT_CYC+1 cycles after the 0x90 write, where WAIT_CYC = (CLK_HZ/1000000)*WAIT_US, with a minimum of 1.
- R3: The manufacturer code is read at address 0 and the device code at address 2. Each read strobe lasts one cycle. `bus_rdata` is sampled at the end of the cycle that follows the strobe, and exactly two reads are made.
- R4: The part counts as recognised only when the manufacturer code equals MFR_CODE and the device code equals DEV_BOOT_CODE or DEV_UNI_CODE. Any other pair gives `valid`=0, `sect_count`=0 and `size_bytes`=0.
- R5: A recognised boot-sector part reports 35 sectors and a size of 0x200000.
- R6: A recognised uniform part reports 128 sectors and a size of 0x800000.
- R7: Boot-sector map without offset: sector 0 starts at 0, sector 1 at 0x4000, sector 2 at 0x6000, sector 3 at 0x8000, and sector i for i ≥ 4 at 0x10000*(i-3).
- R8: Uniform map without offset: sector i starts at 0x10000*i.
- R9: When LOW_BOOT=0, 0xE00000 is added to every boot-part sector start and 0x800000 to every uniform-part sector start.
- R10: After the device-code read, one write of 0xF0 to address 0 follows. `done` is high for exactly the one cycle after that write.
- R11: If `sect_idx` is not below the reported sector count, `sect_base` is 0 and `sect_err` is 1. This includes every index when the part is unrecognised. Otherwise `sect_err` is 0.
- R12: `bus_wr` and `bus_rd` are never high in the same cycle, and both are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a probe when seen in idle |
| bus_addr | output | ADDR_W | Byte address to the flash |
| bus_wdata | output | 8 | Write data to the flash |
| bus_wr | output | 1 | Write strobe, one cycle per access |
| bus_rd | output | 1 | Read strobe, one cycle per access |
| bus_rdata | input | 8 | Read data, valid in the cycle after `bus_rd` |
| done | output | 1 | One-cycle pulse when the probe ends |
| valid | output | 1 | Latched result: part recognised |
| sect_count | output | IDX_W | Number of sectors, 0 when unrecognised |
| size_bytes | output | ADDR_W | Device size in bytes, 0 when unrecognised |
| sect_idx | input | IDX_W | Sector index to look up |
| sect_base | output | ADDR_W | Start address of sector `sect_idx` |
| sect_err | output | 1 | Index out of range or no recognised part |

## Verification
The bench targets the boot-sector map at indices 0 through 4, because a wrong small-sector table shows up first at the jump from 0x8000 to 0x10000. It also targets indices 34/35 and 127/128, where an off-by-one range check would return a nonzero base with no error. Two tests probe an unknown manufacturer paired with a known device code, and a known manufacturer paired with an unknown code; a decoder that checks only one of the two codes would report a size for a part that is absent. The settle gap and the strict write order are measured cycle by cycle. A counter that is off by one, or an unlock step in the wrong order, therefore changes a measured cycle number or a logged address.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

    typedef enum logic [1:0] {
        DEV_NONE   = 2'd0,
        DEV_BOOT16 = 2'd1,
        DEV_UNI64  = 2'd2
    } dev_kind_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLK_A,
        S_UNLK_B,
        S_AUTOSEL,
        S_SETTLE,
        S_RD_MFR,
        S_CAP_MFR,
        S_RD_DEV,
        S_CAP_DEV,
        S_EXIT,
        S_DONE
    } probe_state_t;

endpackage

// File: rtl/nor_id_settle.sv
module nor_id_settle #(
    parameter int CNT_LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic elapsed
);
    localparam int CW = $clog2(CNT_LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign elapsed = (cnt_q == CW'(CNT_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!elapsed) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/nor_id_sector_map.sv
module nor_id_sector_map
    import nor_id_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int IDX_W    = 8,
    parameter bit LOW_BOOT = 1'b0
) (
    input  dev_kind_t         kind,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic              err
);
    localparam logic [ADDR_W-1:0] OFS_BOOT = LOW_BOOT ? '0 : ADDR_W'(24'hE00000);
    localparam logic [ADDR_W-1:0] OFS_UNI  = LOW_BOOT ? '0 : ADDR_W'(24'h800000);
    localparam int                SECT_SH  = 16;

    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw  = '0;
        base = '0;
        err  = 1'b1;
        case (kind)
            DEV_BOOT16: begin
                if (idx < IDX_W'(35)) begin
                    err = 1'b0;
                    if (idx < IDX_W'(4)) begin
                        case (idx[1:0])
                            2'd0:    raw = '0;
                            2'd1:    raw = ADDR_W'(24'h004000);
                            2'd2:    raw = ADDR_W'(24'h006000);
                            default: raw = ADDR_W'(24'h008000);
                        endcase
                    end else begin
                        raw = ADDR_W'(idx - IDX_W'(3)) << SECT_SH;
                    end
                    base = raw + OFS_BOOT;
                end
            end
            DEV_UNI64: begin
                if (idx < IDX_W'(128)) begin
                    err  = 1'b0;
                    raw  = ADDR_W'(idx) << SECT_SH;
                    base = raw + OFS_UNI;
                end
            end
            default: begin
                err = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
    import nor_id_pkg::*;
#(
    parameter int          ADDR_W        = 24,
    parameter int          IDX_W         = 8,
    parameter int          CLK_HZ        = 200_000_000,
    parameter int          WAIT_US       = 100,
    parameter bit          LOW_BOOT      = 1'b0,
    parameter logic [7:0]  MFR_CODE      = 8'h01,
    parameter logic [7:0]  DEV_BOOT_CODE = 8'h49,
    parameter logic [7:0]  DEV_UNI_CODE  = 8'h93
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    output logic              done,
    output logic              valid,
    output logic [IDX_W-1:0]  sect_count,
    output logic [ADDR_W-1:0] size_bytes,
    input  logic [IDX_W-1:0]  sect_idx,
    output logic [ADDR_W-1:0] sect_base,
    output logic              sect_err
);
    localparam int WAIT_RAW = (CLK_HZ / 1_000_000) * WAIT_US;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    localparam logic [ADDR_W-1:0] A_CMD1 = ADDR_W'(12'hAAA);
    localparam logic [ADDR_W-1:0] A_CMD2 = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] A_MFR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DEV  = ADDR_W'(2);

    probe_state_t state_q, state_d;
    dev_kind_t    kind_q;
    logic [7:0]   mfr_q;
    logic         settle_done;

    nor_id_settle #(.CNT_LIMIT(WAIT_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == S_SETTLE),
        .elapsed (settle_done)
    );

    nor_id_sector_map #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .LOW_BOOT (LOW_BOOT)
    ) u_map (
        .kind (kind_q),
        .idx  (sect_idx),
        .base (sect_base),
        .err  (sect_err)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_UNLK_A;
            S_UNLK_A:  state_d = S_UNLK_B;
            S_UNLK_B:  state_d = S_AUTOSEL;
            S_AUTOSEL: state_d = S_SETTLE;
            S_SETTLE:  if (settle_done) state_d = S_RD_MFR;
            S_RD_MFR:  state_d = S_CAP_MFR;
            S_CAP_MFR: state_d = S_RD_DEV;
            S_RD_DEV:  state_d = S_CAP_DEV;
            S_CAP_DEV: state_d = S_EXIT;
            S_EXIT:    state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // captured identification data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_q  <= '0;
            kind_q <= DEV_NONE;
        end else if (state_q == S_IDLE && start) begin
            kind_q <= DEV_NONE;
        end else if (state_q == S_CAP_MFR) begin
            mfr_q <= bus_rdata;
        end else if (state_q == S_CAP_DEV) begin
            if (mfr_q != MFR_CODE)              kind_q <= DEV_NONE;
            else if (bus_rdata == DEV_BOOT_CODE) kind_q <= DEV_BOOT16;
            else if (bus_rdata == DEV_UNI_CODE)  kind_q <= DEV_UNI64;
            else                                 kind_q <= DEV_NONE;
        end
    end

    // outputs
    always_comb begin
        bus_addr   = '0;
        bus_wdata  = '0;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_UNLK_A:  begin bus_wr = 1'b1; bus_addr = A_CMD1; bus_wdata = 8'hAA; end
            S_UNLK_B:  begin bus_wr = 1'b1; bus_addr = A_CMD2; bus_wdata = 8'h55; end
            S_AUTOSEL: begin bus_wr = 1'b1; bus_addr = A_CMD1; bus_wdata = 8'h90; end
            S_RD_MFR:  begin bus_rd = 1'b1; bus_addr = A_MFR; end
            S_RD_DEV:  begin bus_rd = 1'b1; bus_addr = A_DEV; end
            S_EXIT:    begin bus_wr = 1'b1; bus_addr = A_MFR; bus_wdata = 8'hF0; end
            S_DONE:    done = 1'b1;
            default:   ;
        endcase

        valid      = (kind_q != DEV_NONE);
        sect_count = '0;
        size_bytes = '0;
        case (kind_q)
            DEV_BOOT16: begin sect_count = IDX_W'(35);  size_bytes = ADDR_W'(24'h200000); end
            DEV_UNI64:  begin sect_count = IDX_W'(128); size_bytes = ADDR_W'(24'h800000); end
            default:    ;
        endcase
    end
endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              done,
    input logic              valid,
    input logic [IDX_W-1:0]  sect_count,
    input logic [ADDR_W-1:0] size_bytes,
    input logic [IDX_W-1:0]  sect_idx,
    input logic [ADDR_W-1:0] sect_base,
    input logic              sect_err
);
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    a_r1_unlock_order: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == 8'hAA) |=>
        (bus_wr && bus_wdata == 8'h55 && bus_addr == ADDR_W'(12'h555)));

    a_r1_autosel_next: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == 8'h55) |=>
        (bus_wr && bus_wdata == 8'h90 && bus_addr == ADDR_W'(12'hAAA)));

    a_r3_dev_after_mfr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |-> ##2 (bus_rd && bus_addr == ADDR_W'(2)));

    a_r10_done_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == 8'hF0) |=> done);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_unknown_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (sect_count == '0 && size_bytes == '0));

    a_r11_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_idx >= sect_count) |-> (sect_err && sect_base == '0));
endmodule

bind nor_id_probe nor_id_probe_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .done       (done),
    .valid      (valid),
    .sect_count (sect_count),
    .size_bytes (size_bytes),
    .sect_idx   (sect_idx),
    .sect_base  (sect_base),
    .sect_err   (sect_err)
);

// File: tb/test_nor_id_probe.sv
`timescale 1ns/1ps
module test_nor_id_probe;
    localparam int ADDR_W   = 24;
    localparam int IDX_W    = 8;
    localparam int CLK_HZ   = 1_000_000;
    localparam int WAIT_US  = 100;
    localparam int WAIT_CYC = 100;
    localparam logic [7:0] MFR  = 8'h01;
    localparam logic [7:0] BOOT = 8'h49;
    localparam logic [7:0] UNI  = 8'h93;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_wr, bus_rd;
    logic [7:0]        bus_rdata = 8'h00;
    logic              done, valid, sect_err;
    logic [IDX_W-1:0]  sect_count;
    logic [ADDR_W-1:0] size_bytes, sect_base;
    logic [IDX_W-1:0]  sect_idx = '0;

    logic [ADDR_W-1:0] lo_addr, lo_size, lo_base;
    logic [7:0]        lo_wdata;
    logic              lo_wr, lo_rd, lo_done, lo_valid, lo_err;
    logic [IDX_W-1:0]  lo_count;

    nor_id_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US),
                   .LOW_BOOT(1'b0), .MFR_CODE(MFR), .DEV_BOOT_CODE(BOOT), .DEV_UNI_CODE(UNI))
    i_nor_id_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .done(done), .valid(valid),
        .sect_count(sect_count), .size_bytes(size_bytes), .sect_idx(sect_idx),
        .sect_base(sect_base), .sect_err(sect_err));

    nor_id_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US),
                   .LOW_BOOT(1'b1), .MFR_CODE(MFR), .DEV_BOOT_CODE(BOOT), .DEV_UNI_CODE(UNI))
    i_nor_id_probe_low (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(lo_addr), .bus_wdata(lo_wdata),
        .bus_wr(lo_wr), .bus_rd(lo_rd), .bus_rdata(bus_rdata), .done(lo_done), .valid(lo_valid),
        .sect_count(lo_count), .size_bytes(lo_size), .sect_idx(sect_idx),
        .sect_base(lo_base), .sect_err(lo_err));

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    logic [7:0] mem_mfr = 8'h00;
    logic [7:0] mem_dev = 8'h00;

    int n_wr = 0, n_rd = 0, done_c = -1;
    logic [ADDR_W-1:0] wr_a [8];
    logic [7:0]        wr_d [8];
    int                wr_c [8];
    logic [ADDR_W-1:0] rd_a [4];
    int                rd_c [4];

    // flash model and access log, all on the falling edge
    always @(negedge clk) begin
        if (bus_rd) begin
            bus_rdata <= (bus_addr == '0) ? mem_mfr :
                         (bus_addr == ADDR_W'(2)) ? mem_dev : 8'hFF;
            if (n_rd < 4) begin rd_a[n_rd] = bus_addr; rd_c[n_rd] = cyc; end
            n_rd++;
        end
        if (bus_wr) begin
            if (n_wr < 8) begin wr_a[n_wr] = bus_addr; wr_d[n_wr] = bus_wdata; wr_c[n_wr] = cyc; end
            n_wr++;
        end
        if (done) done_c = cyc;
        cyc++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_base(input int kind, input bit low, input int idx);
        longint b;
        b = 0;
        if (kind == 1 && idx < 35) begin
            if (idx == 0) b = 0;
            else if (idx == 1) b = 'h4000;
            else if (idx == 2) b = 'h6000;
            else if (idx == 3) b = 'h8000;
            else b = 'h10000 * (idx - 3);
            if (!low) b = b + 'hE00000;
        end else if (kind == 2 && idx < 128) begin
            b = 'h10000 * idx;
            if (!low) b = b + 'h800000;
        end
        return ADDR_W'(b);
    endfunction

    task automatic probe(input logic [7:0] m, input logic [7:0] d, input int kind);
        int ecnt;
        longint esz;
        mem_mfr = m;
        mem_dev = d;
        n_wr = 0; n_rd = 0; done_c = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        #1;
        // R1 unlock sequence
        check(n_wr == 4, "R1", "write count", n_wr, 4);
        check(wr_a[0] == 'hAAA && wr_d[0] == 8'hAA, "R1", "first write", {wr_a[0], wr_d[0]}, {24'hAAA, 8'hAA});
        check(wr_a[1] == 'h555 && wr_d[1] == 8'h55, "R1", "second write", {wr_a[1], wr_d[1]}, {24'h555, 8'h55});
        check(wr_a[2] == 'hAAA && wr_d[2] == 8'h90, "R1", "third write", {wr_a[2], wr_d[2]}, {24'hAAA, 8'h90});
        check(wr_c[1] == wr_c[0] + 1 && wr_c[2] == wr_c[1] + 1, "R1", "back-to-back", wr_c[2] - wr_c[0], 2);
        // R2 settle gap
        check(rd_c[0] - wr_c[2] == WAIT_CYC + 1, "R2", "settle gap", rd_c[0] - wr_c[2], WAIT_CYC + 1);
        // R3 reads
        check(n_rd == 2, "R3", "read count", n_rd, 2);
        check(rd_a[0] == '0 && rd_a[1] == ADDR_W'(2), "R3", "read addresses", {rd_a[0], rd_a[1]}, {24'h0, 24'h2});
        check(rd_c[1] == rd_c[0] + 2, "R3", "read spacing", rd_c[1] - rd_c[0], 2);
        // R10 exit write and done
        check(wr_a[3] == '0 && wr_d[3] == 8'hF0, "R10", "read-reset write", {wr_a[3], wr_d[3]}, {24'h0, 8'hF0});
        check(wr_c[3] == rd_c[1] + 2, "R10", "read-reset timing", wr_c[3] - rd_c[1], 2);
        check(done_c == wr_c[3] + 1, "R10", "done cycle", done_c - wr_c[3], 1);
        @(negedge clk);
        check(!done, "R10", "done single pulse", done, 0);
        // R4 R5 R6 result
        ecnt = (kind == 1) ? 35 : (kind == 2) ? 128 : 0;
        esz  = (kind == 1) ? 'h200000 : (kind == 2) ? 'h800000 : 0;
        check(valid == (kind != 0), "R4", "valid", valid, kind != 0);
        check(sect_count == ecnt, (kind == 1) ? "R5" : (kind == 2) ? "R6" : "R4", "sector count", sect_count, ecnt);
        check(size_bytes == esz, (kind == 1) ? "R5" : (kind == 2) ? "R6" : "R4", "size", size_bytes, esz);
        check(lo_valid == valid && lo_count == sect_count, "R4", "low instance result", lo_count, ecnt);
        // R7 R8 R9 R11 sector sweep
        for (int i = 0; i < 256; i++) begin
            bit inr;
            string tg;
            sect_idx = IDX_W'(i);
            #1;
            inr = (i < ecnt);
            tg  = !inr ? "R11" : (kind == 1) ? "R7" : "R8";
            check(lo_base == exp_base(kind, 1'b1, i), tg, $sformatf("low base idx %0d", i), lo_base, exp_base(kind, 1'b1, i));
            check(lo_err == !inr, tg, $sformatf("low err idx %0d", i), lo_err, !inr);
            check(sect_base == exp_base(kind, 1'b0, i), inr ? "R9" : "R11", $sformatf("high base idx %0d", i), sect_base, exp_base(kind, 1'b0, i));
            check(sect_err == !inr, inr ? "R9" : "R11", $sformatf("high err idx %0d", i), sect_err, !inr);
        end
        sect_idx = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // reset state: R12 idle strobes, R4 nothing recognised
        check(!bus_wr && !bus_rd, "R12", "idle strobes", {bus_wr, bus_rd}, 0);
        check(!done, "R10", "done after reset", done, 0);
        check(!valid && sect_count == 0 && size_bytes == 0, "R4", "reset result", {valid, sect_count}, 0);
        check(sect_err && sect_base == 0, "R11", "reset lookup", {sect_err, sect_base}, {1'b1, 24'h0});

        probe(MFR, BOOT, 1);
        probe(MFR, UNI, 2);
        probe(8'h20, BOOT, 0);
        probe(MFR, 8'h22, 0);
        probe(8'hFF, UNI, 0);
        probe(MFR, UNI, 2);

        repeat (3) @(negedge clk);
        check(!bus_wr && !bus_rd, "R12", "idle after probes", {bus_wr, bus_rd}, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule